// File: doc/BRIEF.md
# Shift-Register Upset Counter With Voting

This block is a soft-error test core for radiation testing. It runs in a single test clock domain. A start pulse arms a run. While the run is active, a square-wave bit stream that alternates every cycle is shifted into a long flip-flop chain. Each bit that leaves the chain is compared with the value the stream must have had when it entered. Every disagreement increments three redundant saturating counters. A bitwise two-of-three vote of those counters forms the reported count.

A free-running timebase counter sets the run length. The run ends in the cycle after a chosen timebase bit goes high. The core then raises its done flag and freezes the count until the next start, so the count can be read at leisure. Checking waits until the chain has filled with fresh pattern after each start, so stale contents from an earlier run are never counted.

A single upset input inverts the bit that enters the chain in that cycle. This lets a bench, or a bring-up setup, plant a known number of errors. In the beam it is tied low. The chain length, counter width and trigger bit are parameters, so short runs can be used in simulation and the full 2^33-cycle run can be used on silicon. The logic is meant to close timing at test clocks of up to 240 MHz.

Top module: `sru_top`

## Requirements
- R1: While rst_ni is low, and after reset before any start, done_o is 0 and err_count_o is 0.
- R2: A cycle with start_i high clears the count and done_o and begins a new run, even if a run is active or done. The count reads 0 in the next cycle.
- R3: The stream entering the chain alternates 0,1,0,1,… beginning with 0 on the first active cycle. With no upsets, a full run ends with a count of 0 for both odd and even chain lengths.
- R4: A flip_i pulse sampled on active cycle m (cycle 1 is the first edge after the start edge) corrupts one chain bit. The count rises by exactly 1 at edge m+CHAIN_LEN, and it increases by at most 1 per cycle.
- R5: No comparison is made during the first CHAIN_LEN active cycles after start, so contents left in the chain from a previous run never add to the count.
- R6: The timebase counts active cycles. Active cycles are 1 to 2^TRIG_BIT. done_o rises after edge 2^TRIG_BIT+1. A corrupted bit is counted only if it reaches the chain output by the last active cycle, so flips at m ≤ 2^TRIG_BIT−CHAIN_LEN are counted.
- R7: Once done_o is high, it stays high and err_count_o stays constant until the next start, whatever flip_i does.
- R8: Each counter saturates at 2^CNT_W−1 and does not wrap.
- R9: The three counters see the same increments, and err_count_o is their bitwise two-of-three majority.
- R10: flip_i has no effect when no run is active, either before the first start or after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start/restart pulse for a run |
| flip_i | input | 1 | Inverts the bit entering the chain this cycle (upset injection) |
| done_o | output | 1 | Run has ended; count is frozen |
| err_count_o | output | CNT_W | Voted mismatch count |

## Verification
The assertions check on every cycle that done holds, that the count is frozen after done, that start clears the state, that each counter steps by at most one and never wraps, that the three counter lanes agree, and that the timebase stays still outside a run. Only the bench scenarios can show the end-to-end arithmetic. That arithmetic covers the exact latency from an injected flip to the count, the boundary flip that just misses the end of the run, saturation on a narrow counter, and the zero count on a restart with stale chain contents. The bench shows this for both an even and an odd chain length.

// File: rtl/sru_pkg.sv
package sru_pkg;
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sru_timebase.sv
module sru_timebase #(
  parameter int TRIG_BIT = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic trig_o
);
  localparam int TW = TRIG_BIT + 1;
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] tb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tb_q <= '0;
    else if (clear_i) tb_q <= '0;
    else if (step_i)  tb_q <= tb_q + ONE;
  end

  assign trig_o = tb_q[TRIG_BIT];

  AST_TB_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !step_i |=> $stable(tb_q)); // R6
endmodule

// File: rtl/sru_chain.sv
module sru_chain #(
  parameter int CHAIN_LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic flip_i,
  output logic mismatch_o
);
  localparam int FW = $clog2(CHAIN_LEN + 1);
  localparam logic [FW-1:0] FULL = FW'(CHAIN_LEN);
  localparam logic [FW-1:0] ONE  = FW'(1);
  localparam logic ODD = (CHAIN_LEN % 2) == 1;

  logic                 pat_q;
  logic [FW-1:0]        fill_q;
  logic [CHAIN_LEN-1:0] chain_q;
  logic                 filled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= 1'b0;
      fill_q <= '0;
    end else if (clear_i) begin
      pat_q  <= 1'b0;
      fill_q <= '0;
    end else if (step_i) begin
      pat_q <= ~pat_q;
      if (fill_q != FULL) fill_q <= fill_q + ONE;
    end
  end

  // stage 0 takes the pattern; later stages copy their neighbour
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chain_q[0] <= 1'b0;
    else if (step_i) chain_q[0] <= pat_q ^ flip_i;
  end

  for (genvar i = 1; i < CHAIN_LEN; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     chain_q[i] <= 1'b0;
      else if (step_i) chain_q[i] <= chain_q[i-1];
    end
  end

  assign filled = (fill_q == FULL);
  // alternating stream: output lags by CHAIN_LEN cycles, i.e. parity of length
  assign mismatch_o = step_i & filled & (chain_q[CHAIN_LEN-1] != (pat_q ^ ODD));

  AST_FILL_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> fill_q >= $past(fill_q)); // R5
endmodule

// File: rtl/sru_tmr_count.sv
module sru_tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  import sru_pkg::*;

  localparam int LANES = 3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      cnt_q[l] <= '0;
      else if (clear_i)                 cnt_q[l] <= '0;
      else if (inc_i && ~&cnt_q[l])     cnt_q[l] <= cnt_q[l] + ONE;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i && (&cnt_q[l]) |=> &cnt_q[l]); // R8
    AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i |=> (cnt_q[l] == $past(cnt_q[l])) ||
                   (cnt_q[l] == CNT_W'($past(cnt_q[l]) + ONE))); // R4
  end

  for (genvar b = 0; b < CNT_W; b++) begin : g_vote
    assign count_o[b] = maj3(cnt_q[0][b], cnt_q[1][b], cnt_q[2][b]);
  end

  AST_LANES_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q[0] == cnt_q[1]) && (cnt_q[1] == cnt_q[2])); // R9
endmodule

// File: rtl/sru_top.sv
module sru_top #(
  parameter int CHAIN_LEN = 64,
  parameter int TRIG_BIT  = 33,
  parameter int CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             flip_i,
  output logic             done_o,
  output logic [CNT_W-1:0] err_count_o
);
  logic running_q, done_q;
  logic trig, active, mismatch;

  assign active = running_q & ~trig & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
    end else if (start_i) begin
      running_q <= 1'b1;
      done_q    <= 1'b0;
    end else if (running_q && trig) begin
      running_q <= 1'b0;
      done_q    <= 1'b1;
    end
  end

  sru_timebase #(.TRIG_BIT(TRIG_BIT)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i),
    .step_i(active), .trig_o(trig)
  );

  sru_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i),
    .step_i(active), .flip_i(flip_i), .mismatch_o(mismatch)
  );

  sru_tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i),
    .inc_i(mismatch), .count_o(err_count_o)
  );

  assign done_o = done_q;

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !start_i |=> done_q); // R7
  AST_COUNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !start_i |=> $stable(err_count_o)); // R7
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_q && (err_count_o == '0)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_q && !start_i |=> $stable(err_count_o)); // R10
endmodule

// File: tb/tb_sru_top.sv
module tb_sru_top;
  localparam int CLK_PERIOD = 10;
  localparam int TRIG = 7;
  localparam int RUN  = 1 << TRIG;
  localparam int NA = 12, WA = 8;
  localparam int NB = 7,  WB = 3;
  localparam int LAST_E = RUN + 12;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, flip_i = 1'b0;
  logic done_a, done_b;
  logic [WA-1:0] cnt_a;
  logic [WB-1:0] cnt_b;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sru_top #(.CHAIN_LEN(NA), .TRIG_BIT(TRIG), .CNT_W(WA)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .flip_i(flip_i),
    .done_o(done_a), .err_count_o(cnt_a));
  sru_top #(.CHAIN_LEN(NB), .TRIG_BIT(TRIG), .CNT_W(WB)) dut_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .flip_i(flip_i),
    .done_o(done_b), .err_count_o(cnt_b));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit flip_at(input int mode, input int e);
    case (mode)
      1: return e == 5;
      2: return (e % 3) == 1;
      3: return e == RUN-NA || e == RUN-NA+1 || e == RUN-NB || e == RUN-NB+1;
      4: return e > RUN;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int expect_cnt(input int mode, input int n, input int w);
    int c = 0;
    for (int m = 1; m <= LAST_E; m++)
      if (flip_at(mode, m) && m <= RUN - n) c++;
    if (c > (1 << w) - 1) c = (1 << w) - 1;
    return c;
  endfunction

  task automatic run(input int mode, input string req);
    int ea, eb;
    @(negedge clk_i); start_i = 1'b1; flip_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i); start_i = 1'b0;
    chk("R2 count cleared", int'(cnt_a), 0);
    chk("R2 done cleared", int'(done_a), 0);
    flip_i = flip_at(mode, 1);
    for (int e = 1; e <= LAST_E; e++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (mode == 1 && e == 4 + NA) chk("R4 no count before latency", int'(cnt_a), 0);
      if (mode == 1 && e == 5 + NA) chk("R4 count at latency", int'(cnt_a), 1);
      if (e == RUN)     chk("R6 done low at last active edge", int'(done_a), 0);
      if (e == RUN + 1) chk("R6 done rises", int'(done_a), 1);
      if (e == RUN + 1) chk("R6 done rises odd chain", int'(done_b), 1);
      flip_i = flip_at(mode, e + 1);
    end
    flip_i = 1'b0;
    ea = expect_cnt(mode, NA, WA);
    eb = expect_cnt(mode, NB, WB);
    chk({req, " even chain count"}, int'(cnt_a), ea);
    chk({req, " odd chain count"}, int'(cnt_b), eb);
    chk("R7 done held", int'(done_a & done_b), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    chk("R1 done in reset", int'(done_a), 0);
    chk("R1 count in reset", int'(cnt_a), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R10: upsets before any start leave nothing behind
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i); flip_i = i[0];
    end
    @(negedge clk_i); flip_i = 1'b0;
    chk("R10 idle flips ignored", int'(cnt_a), 0);
    chk("R1 done after reset", int'(done_a), 0);
    run(0, "R3 clean run");
    run(1, "R4 single upset");
    run(2, "R8 dense upsets saturate");
    run(0, "R5 restart with stale chain");
    run(3, "R6 boundary upsets");
    run(4, "R7 R10 flips after done");
    // R2: restart while a run is active
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; flip_i = 1'b1;
    @(negedge clk_i); flip_i = 1'b0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk("R2 restart mid-run clears", int'(cnt_a), 0);
    for (int i = 0; i < RUN + 4; i++) @(negedge clk_i);
    chk("R9 voted count after clean restart", int'(cnt_a), 0);
    chk("R2 restarted run completes", int'(done_a), 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule